// File: doc/BRIEF.md
# Status and Interrupt Vector Unit

This unit holds the sixteen event flags of a serial bus controller and the mask that decides which of them may interrupt the host. It turns those flags into one interrupt line and two DMA request lines. The transfer engine next to it raises flags with one-cycle set pulses and may drop them with hardware clear pulses. Software reaches the unit through a small register port with four selects: enable mask, status, vector and DMA configuration.

A status write acknowledges only the event flags that software owns. The receive-ready flag (bit 3) and the transmit-ready flag (bit 4) are left for hardware to drop. A vector read reports the lowest pending enabled source as its index plus one, or zero when none is pending, and acknowledges that source in the same access. Turning on DMA for a direction removes that direction's ready flag from the interrupt mask, so the flag then drives only its DMA request.

Top module: `siv_unit`

## Requirements
- R1: After reset the status, enable mask and DMA configuration are all zero, irq_o, dma_rx_req_o, dma_tx_req_o and rd_valid_o are low, and a status read returns 0.
- R2: An enable-mask write (select 0) keeps only the low 6 bits (5 when NEW_REV is 0), and a read of select 0 returns them zero-extended.
- R3: A status write (select 1) clears exactly the status bits that are set both in the written value and in 0x0027. Bits 3 (receive ready) and 4 (transmit ready) and all other bits keep their value.
- R4: A set pulse on evt_set_i[n] sets status bit n and a pulse on evt_clr_i[n] clears it. When both arrive in the same cycle, the set wins.
- R5: A status read returns bit 12 equal to bus_busy_i sampled in the access cycle, ORed onto the stored status.
- R6: irq_o is high exactly when (status AND enable mask) is nonzero. It follows the clock edge that changes either of them.
- R7: A vector read (select 2) returns n+1, where n is the lowest set bit of (status AND enable mask), or 0 when that value is zero.
- R8: A vector read clears the status bit it reports, and irq_o is re-evaluated on the same edge. Any set pulse arriving in the same cycle still wins.
- R9: A DMA configuration write (select 3) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A read of select 3 returns only those bits.
- R10: A DMA configuration write with bit 15 set clears enable-mask bit 3, and one with bit 7 set clears enable-mask bit 4.
- R11: dma_rx_req_o equals (receive DMA enable AND status bit 3), and dma_tx_req_o equals (transmit DMA enable AND status bit 4).
- R12: Every read gives rd_valid_o high for exactly one cycle, with rd_data_o valid, on the edge that takes the access. Writes do not raise rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_sel_i | input | 2 | 0 enable, 1 status, 2 vector, 3 DMA configuration |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |
| evt_set_i | input | 16 | Status set pulses from the transfer engine |
| evt_clr_i | input | 16 | Status clear pulses from the transfer engine |
| bus_busy_i | input | 1 | Bus busy indication |
| irq_o | output | 1 | Interrupt request |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |

## Verification
The assertions assume that rst_n drives the internal reset through the two-stage synchronizer. They also assume that a status write checked for R3 arrives in a cycle with no engine set or clear pulse, because those pulses may legally change bits 3 and 4. The stimulus applies at most one register access per cycle. Event pulses come in cycles apart from register writes, except where the set-versus-clear ordering of R4 is under test, and every input changes on the falling edge.

// File: rtl/siv_pkg.sv
package siv_pkg;

  localparam int STAT_W      = 16;
  localparam int BIT_RX_RDY  = 3;
  localparam int BIT_TX_RDY  = 4;
  localparam int BIT_BUSY    = 12;
  localparam int BIT_DMA_RX  = 15;
  localparam int BIT_DMA_TX  = 7;
  localparam logic [STAT_W-1:0] SW_ACK_MASK = 16'h0027;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_DMACFG = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/siv_vector_enc.sv
module siv_vector_enc #(
  parameter int W  = 6,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  pend_i,
  output logic [W-1:0]  first_o,
  output logic [CW-1:0] code_o
);

  // lower_seen[i] is high when any bit below i is pending
  logic [W:0] lower_seen;
  assign lower_seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_chain
      assign lower_seen[gi+1] = lower_seen[gi] | pend_i[gi];
      assign first_o[gi]      = pend_i[gi] & ~lower_seen[gi];
    end
  endgenerate

  always_comb begin
    code_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first_o[i]) code_o = code_o | CW'(i + 1);
    end
  end

endmodule

// File: rtl/siv_enable_reg.sv
module siv_enable_reg
  import siv_pkg::*;
#(
  parameter int IE_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mask_i,
  input  logic            wr_dma_i,
  input  logic [15:0]     wdata_i,
  output logic [IE_W-1:0] en_q_o,
  output logic [IE_W-1:0] en_d_o,
  output logic            dma_rx_q_o,
  output logic            dma_tx_q_o,
  output logic            dma_rx_d_o,
  output logic            dma_tx_d_o
);

  logic [IE_W-1:0] en_q, en_d;
  logic            rx_q, rx_d, tx_q, tx_d;
  logic [IE_W-1:0] dma_kill;
  logic            en_ce, dma_ce;

  assign en_ce  = wr_mask_i | wr_dma_i;
  assign dma_ce = wr_dma_i;

  always_comb begin
    dma_kill = '0;
    dma_kill[BIT_RX_RDY] = wdata_i[BIT_DMA_RX];
    dma_kill[BIT_TX_RDY] = wdata_i[BIT_DMA_TX];
  end

  always_comb begin
    en_d = en_q;
    rx_d = rx_q;
    tx_d = tx_q;
    if (wr_mask_i) begin
      en_d = wdata_i[IE_W-1:0];
    end
    if (wr_dma_i) begin
      rx_d = wdata_i[BIT_DMA_RX];
      tx_d = wdata_i[BIT_DMA_TX];
      en_d = en_q & ~dma_kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else if (dma_ce) begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign en_q_o     = en_q;
  assign en_d_o     = en_d;
  assign dma_rx_q_o = rx_q;
  assign dma_tx_q_o = tx_q;
  assign dma_rx_d_o = rx_d;
  assign dma_tx_d_o = tx_d;

endmodule

// File: rtl/siv_status_reg.sv
module siv_status_reg
  import siv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_val_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] stat_q_o,
  output logic [W-1:0] stat_d_o
);

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] drop;
  logic         stat_ce;

  always_comb begin
    drop = hw_clr_i | ack_i;
    if (sw_wr_i) drop = drop | (sw_val_i & SW_ACK_MASK[W-1:0]);
  end

  // set pulses take priority over every clear source
  assign stat_d  = (stat_q & ~drop) | set_i;
  assign stat_ce = (|set_i) | (|drop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  assign stat_q_o = stat_q;
  assign stat_d_o = stat_d;

endmodule

// File: rtl/siv_unit.sv
module siv_unit
  import siv_pkg::*;
#(
  parameter int NEW_REV = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [1:0]  req_sel_i,
  input  logic [15:0] req_wdata_i,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o,
  input  logic [15:0] evt_set_i,
  input  logic [15:0] evt_clr_i,
  input  logic        bus_busy_i,
  output logic        irq_o,
  output logic        dma_rx_req_o,
  output logic        dma_tx_req_o
);

  localparam int IE_W = (NEW_REV != 0) ? 6 : 5;
  localparam int CW   = $clog2(IE_W + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // access decode
  reg_sel_e sel;
  logic     wr_mask, wr_stat, wr_dma, rd_fire, vec_rd;

  assign sel     = reg_sel_e'(req_sel_i);
  assign rd_fire = req_valid_i & ~req_write_i;
  assign wr_mask = req_valid_i &  req_write_i & (sel == SEL_ENABLE);
  assign wr_stat = req_valid_i &  req_write_i & (sel == SEL_STATUS);
  assign wr_dma  = req_valid_i &  req_write_i & (sel == SEL_DMACFG);
  assign vec_rd  = rd_fire & (sel == SEL_VECTOR);

  // enable mask and DMA configuration
  logic [IE_W-1:0] en_q, en_d;
  logic            dma_rx_en_q, dma_tx_en_q, dma_rx_en_d, dma_tx_en_d;

  siv_enable_reg #(.IE_W(IE_W)) u_enable (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_mask_i  (wr_mask),
    .wr_dma_i   (wr_dma),
    .wdata_i    (req_wdata_i),
    .en_q_o     (en_q),
    .en_d_o     (en_d),
    .dma_rx_q_o (dma_rx_en_q),
    .dma_tx_q_o (dma_tx_en_q),
    .dma_rx_d_o (dma_rx_en_d),
    .dma_tx_d_o (dma_tx_en_d)
  );

  // vector encoder over the pending enabled sources
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [IE_W-1:0]   pend, first;
  logic [CW-1:0]     vec_code;
  logic [STAT_W-1:0] ack;

  assign pend = stat_q[IE_W-1:0] & en_q;

  siv_vector_enc #(.W(IE_W), .CW(CW)) u_vec (
    .pend_i  (pend),
    .first_o (first),
    .code_o  (vec_code)
  );

  always_comb begin
    ack = '0;
    if (vec_rd) ack[IE_W-1:0] = first;
  end

  // status flags
  siv_status_reg #(.W(STAT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set_i    (evt_set_i),
    .hw_clr_i (evt_clr_i),
    .sw_wr_i  (wr_stat),
    .sw_val_i (req_wdata_i),
    .ack_i    (ack),
    .stat_q_o (stat_q),
    .stat_d_o (stat_d)
  );

  // read-back multiplexer
  logic [15:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_ENABLE: rd_mux[IE_W-1:0] = en_q;
      SEL_STATUS: begin
        rd_mux           = stat_q;
        rd_mux[BIT_BUSY] = stat_q[BIT_BUSY] | bus_busy_i;
      end
      SEL_VECTOR: rd_mux[CW-1:0] = vec_code;
      SEL_DMACFG: begin
        rd_mux[BIT_DMA_RX] = dma_rx_en_q;
        rd_mux[BIT_DMA_TX] = dma_tx_en_q;
      end
      default: rd_mux = '0;
    endcase
  end

  // output registers, next state computed from next register values
  logic        irq_d, drx_d, dtx_d;
  logic        irq_q, drx_q, dtx_q, rdv_q;
  logic [15:0] rdd_q;

  assign irq_d = |(stat_d[IE_W-1:0] & en_d);
  assign drx_d = dma_rx_en_d & stat_d[BIT_RX_RDY];
  assign dtx_d = dma_tx_en_d & stat_d[BIT_TX_RDY];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q <= 1'b0;
      drx_q <= 1'b0;
      dtx_q <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      drx_q <= drx_d;
      dtx_q <= dtx_d;
      rdv_q <= rd_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdd_q <= '0;
    end else if (rd_fire) begin
      rdd_q <= rd_mux;
    end
  end

  assign irq_o        = irq_q;
  assign dma_rx_req_o = drx_q;
  assign dma_tx_req_o = dtx_q;
  assign rd_valid_o   = rdv_q;
  assign rd_data_o    = rdd_q;

endmodule

// File: rtl/siv_unit_chk.sv
module siv_unit_chk #(
  parameter int IE_W = 6
) (
  input logic            clk,
  input logic            rst_s_n,
  input logic            req_valid_i,
  input logic            req_write_i,
  input logic [1:0]      req_sel_i,
  input logic [15:0]     req_wdata_i,
  input logic [15:0]     evt_set_i,
  input logic [15:0]     evt_clr_i,
  input logic [15:0]     stat_q,
  input logic [IE_W-1:0] en_q,
  input logic            dma_rx_en_q,
  input logic            dma_tx_en_q,
  input logic            irq_o,
  input logic            dma_rx_req_o,
  input logic            dma_tx_req_o,
  input logic            rd_valid_o
);

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o == (|(stat_q[IE_W-1:0] & en_q)));

  // R11
  dma_rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dma_rx_req_o == (dma_rx_en_q & stat_q[3]));

  // R11
  dma_tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dma_tx_req_o == (dma_tx_en_q & stat_q[4]));

  // R3
  ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid_i && req_write_i && req_sel_i == 2'd1 &&
     evt_set_i == '0 && evt_clr_i == '0)
    |=> (stat_q[4:3] == $past(stat_q[4:3])));

  // R10
  rx_dma_kill_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid_i && req_write_i && req_sel_i == 2'd3 && req_wdata_i[15])
    |=> !en_q[3]);

  // R12
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid_i && !req_write_i) |=> rd_valid_o);

  // R12
  wr_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!(req_valid_i && !req_write_i)) |=> !rd_valid_o);

endmodule

bind siv_unit siv_unit_chk #(.IE_W(IE_W)) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_sel_i    (req_sel_i),
  .req_wdata_i  (req_wdata_i),
  .evt_set_i    (evt_set_i),
  .evt_clr_i    (evt_clr_i),
  .stat_q       (stat_q),
  .en_q         (en_q),
  .dma_rx_en_q  (dma_rx_en_q),
  .dma_tx_en_q  (dma_tx_en_q),
  .irq_o        (irq_o),
  .dma_rx_req_o (dma_rx_req_o),
  .dma_tx_req_o (dma_tx_req_o),
  .rd_valid_o   (rd_valid_o)
);

// File: tb/test_siv_unit.sv
`timescale 1ns/1ps
module test_siv_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_sel;
  logic [15:0] req_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [15:0] evt_set, evt_clr;
  logic        bus_busy;
  logic        irq, dma_rx, dma_tx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  siv_unit i_siv_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_write_i  (req_write),
    .req_sel_i    (req_sel),
    .req_wdata_i  (req_wdata),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data),
    .evt_set_i    (evt_set),
    .evt_clr_i    (evt_clr),
    .bus_busy_i   (bus_busy),
    .irq_o        (irq),
    .dma_rx_req_o (dma_rx),
    .dma_tx_req_o (dma_tx)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access per call, outputs visible at the following falling edge
  task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    evt_set = s; evt_clr = c;
    @(negedge clk);
    evt_set = '0; evt_clr = '0;
  endtask

  // monitor: compares each read result with the oldest expected item
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected rd_valid actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = '0;
    req_wdata = '0; evt_set = '0; evt_clr = '0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 dma", {14'd0, dma_rx, dma_tx}, 16'd0);
    check("R12 rd_valid idle", {15'd0, rd_valid}, 16'd0);
    reg_read(2'd1, 16'h0000, "R1 status");
    reg_read(2'd0, 16'h0000, "R1 enable");

    // R2 mask width
    reg_write(2'd0, 16'hFFFF);
    reg_read(2'd0, 16'h003F, "R2 enable width");

    // R6 irq follows a newly set enabled bit
    check("R6 irq before", {15'd0, irq}, 16'd0);
    pulse(16'h0002, 16'h0000);
    check("R6 irq after set", {15'd0, irq}, 16'd1);

    // R3 selective software acknowledge
    pulse(16'h013F, 16'h0000);
    reg_read(2'd1, 16'h013F, "R4 status after set");
    reg_write(2'd1, 16'hFFFF);
    reg_read(2'd1, 16'h0118, "R3 status after w1c");

    // R5 busy bit
    @(negedge clk); bus_busy = 1'b1;
    reg_read(2'd1, 16'h1118, "R5 busy in status");
    @(negedge clk); bus_busy = 1'b0;

    // R7 / R8 vector reads
    reg_read(2'd2, 16'h0004, "R7 vector lowest is bit3");
    reg_read(2'd1, 16'h0110, "R8 vector cleared bit3");
    reg_read(2'd2, 16'h0005, "R7 vector next is bit4");
    check("R8 irq after last enabled ack", {15'd0, irq}, 16'd0);
    reg_read(2'd2, 16'h0000, "R7 vector none pending");
    reg_read(2'd1, 16'h0100, "R8 status after acks");

    // R4 set versus clear ordering
    pulse(16'h0004, 16'h0004);
    reg_read(2'd1, 16'h0104, "R4 set wins over clear");
    pulse(16'h0000, 16'h0100);
    reg_read(2'd1, 16'h0004, "R4 hardware clear");
    pulse(16'h0000, 16'h0004);
    reg_read(2'd1, 16'h0000, "R4 hardware clear bit2");

    // R9 / R10 DMA configuration
    reg_write(2'd3, 16'hFFFF);
    reg_read(2'd3, 16'h8080, "R9 dma cfg kept bits");
    reg_read(2'd0, 16'h0027, "R10 ready enables dropped");

    // R11 DMA requests follow ready flags
    pulse(16'h0008, 16'h0000);
    check("R11 dma_rx on", {15'd0, dma_rx}, 16'd1);
    check("R11 dma_tx off", {15'd0, dma_tx}, 16'd0);
    check("R10 irq masked rx ready", {15'd0, irq}, 16'd0);
    pulse(16'h0010, 16'h0000);
    check("R11 dma_tx on", {15'd0, dma_tx}, 16'd1);
    reg_write(2'd3, 16'h0000);
    check("R11 dma lines off", {14'd0, dma_rx, dma_tx}, 16'd0);
    reg_read(2'd1, 16'h0018, "R3 ready flags remain");

    repeat (4) @(negedge clk);
    check("R12 all reads returned", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule